// File: doc/BRIEF.md
# Host-Mastered DMA Slave Port

This block lets a device outside the chip drive data transfers as the bus master, while the chip only answers. The host uses a simple asynchronous memory-style handshake: an active-low chip select, active-low read and write strobes, an address-select line and a data bus. With the address-select line high, the host reaches a configuration word, which is passed to the internal DMA engine, or a status word, which reports how full the FIFO is and which way data flows. With the line low, the host pushes words into, or pulls words out of, an eight-word internal FIFO.

Internal logic sets up the port with a small control write. That write holds the enable, the host bus width (8 or 16 bits), the byte order and the flow-control style. Flow runs in one direction at a time, picked by the host's configuration word. In byte mode, two host accesses make up one 16-bit internal word. In acknowledge mode, an ACK output holds off each host access until the FIFO can take or give data. In interrupt mode, the port raises a request to the host only when a full FIFO-depth burst can finish without a stall.

Top module: `host_dma_slave`

## Requirements
- R1: While the port is disabled, hostAck, hostIrq, toIntValid and fromIntReady are all low. Host accesses are ignored: no config strobe is produced and the FIFO does not change.
- R2: Each pulse on ctlWr loads the control fields from ctlWrData: bit 0 enable, bit 1 16-bit bus (0 means 8-bit), bit 2 big-endian, bit 3 acknowledge mode (0 means interrupt mode). The same pulse flushes the FIFO and the byte phase.
- R3: A host write with hostAddrSel=1 loads cfgWord and pulses cfgStrobe high for one cycle. In 8-bit mode only bits [7:0] are taken and the upper byte reads zero. Bit 0 of the word sets the direction: 1 means host to internal, 0 means internal to host. The write also empties the FIFO.
- R4: A host read with hostAddrSel=1 returns the status word. Bits [3:0] hold the FIFO level (0 to 8), bit 4 holds the direction bit, and all other bits are zero.
- R5: In 16-bit mode, a host data write pushes hostDataIn as it is for little-endian, or with its two bytes swapped for big-endian. The word then appears on toIntData.
- R6: In 8-bit mode, two host data writes make one internal word. For little-endian, the first byte becomes bits [7:0]. For big-endian, the first byte becomes bits [15:8]. Bits [15:8] of hostDataIn are ignored.
- R7: Host data reads return FIFO words. In 16-bit mode the word is returned as it is, or byte-swapped for big-endian. In 8-bit mode each word takes two reads, zero-extended: low byte first for little-endian, high byte first for big-endian. The word is popped on the second read.
- R8: The port is half-duplex. A data access against the current direction is acknowledged but has no effect: a write changes nothing, and a read returns 0. Only the stream of the active direction can carry data.
- R9: In acknowledge mode, hostAck stays low until the access has been carried out, then stays high until the strobe is released. A data write waits while the FIFO is full. A data read waits while it is empty.
- R10: In interrupt mode, hostAck is held high while the port is enabled. hostIrq is high exactly when the FIFO is empty in the host-to-internal direction, or full (8 words) in the internal-to-host direction.
- R11: The FIFO holds 8 words. fromIntReady drops once 8 words are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctlWr | input | 1 | Internal control write strobe |
| ctlWrData | input | 4 | Control fields (enable, width, endian, ack mode) |
| hostCsN | input | 1 | Host chip select, active low |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostAddrSel | input | 1 | 1 = config/status, 0 = data FIFO |
| hostDataIn | input | 16 | Host write data |
| hostDataOut | output | 16 | Host read data |
| hostDataOe | output | 1 | Drive enable for the host data bus |
| hostAck | output | 1 | Access complete / flow control |
| hostIrq | output | 1 | Burst-ready request to the host |
| cfgWord | output | 16 | Last configuration word from the host |
| cfgStrobe | output | 1 | One-cycle pulse on a new config word |
| toIntData | output | 16 | Word toward the internal DMA engine |
| toIntValid | output | 1 | toIntData valid |
| toIntReady | input | 1 | Internal side takes the word |
| fromIntData | input | 16 | Word from the internal DMA engine |
| fromIntValid | input | 1 | fromIntData valid |
| fromIntReady | output | 1 | Port accepts the word |

## Verification
The bench sweeps all four combinations of bus width and byte order in both directions. It uses word values whose two bytes differ, so the bench can tell a byte swap from no swap, and a low-byte-first order from a high-byte-first order. Accesses against the current direction show whether data leaks across the half-duplex boundary. Held strobes against a full or empty FIFO show whether acknowledge mode stalls at the right point. FIFO levels of zero and eight, in each direction, exercise the interrupt condition at both of its boundaries.

// File: rtl/host_port_pkg.sv
package host_port_pkg;

  // Strobes from the control FSM to the datapath, one per host action
  typedef struct packed {
    logic holdLo;      // latch first byte of an 8-bit write
    logic pushWord;    // push packed host word
    logic loadData;    // load read register from FIFO head
    logic popWord;     // pop FIFO head for the host
    logic loadStatus;  // load read register with status
    logic clearRead;   // load read register with zero
    logic flush;       // empty the FIFO
  } strobeT;

endpackage

// File: rtl/hport_ctrl.sv
module hport_ctrl
  import host_port_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWr,
  input  logic [3:0]       ctlWrData,
  input  logic             hostCsN,
  input  logic             hostRdN,
  input  logic             hostWrN,
  input  logic             hostAddrSel,
  input  logic [15:0]      hostDataIn,
  input  logic [LVL_W-1:0] level,
  output strobeT           stb,
  output logic             enable,
  output logic             wide,
  output logic             bigEnd,
  output logic             ackMode,
  output logic             dirWrite,
  output logic             secondByte,
  output logic [15:0]      cfgWord,
  output logic             cfgStrobe,
  output logic             hostAck,
  output logic             hostIrq
);

  logic active, isWr, isRd, dataWrGo, dataRdGo, canGo, commit, doneFlag;
  logic fifoFull, fifoEmpty, cfgHit;

  assign fifoFull  = (level == LVL_W'(DEPTH));
  assign fifoEmpty = (level == '0);

  assign isWr     = !hostWrN;
  assign isRd     = hostWrN && !hostRdN;
  assign active   = enable && !hostCsN && (isWr || isRd);
  assign dataWrGo = isWr && !hostAddrSel && dirWrite;
  assign dataRdGo = isRd && !hostAddrSel && !dirWrite;

  always_comb begin
    if (dataWrGo)      canGo = !fifoFull || (!wide && !secondByte);
    else if (dataRdGo) canGo = !fifoEmpty;
    else               canGo = 1'b1;
  end

  assign commit = active && canGo && !doneFlag;
  assign cfgHit = commit && isWr && hostAddrSel;

  always_comb begin
    stb            = '0;
    stb.holdLo     = commit && dataWrGo && !wide && !secondByte;
    stb.pushWord   = commit && dataWrGo && (wide || secondByte);
    stb.loadData   = commit && dataRdGo;
    stb.popWord    = commit && dataRdGo && (wide || secondByte);
    stb.loadStatus = commit && isRd && hostAddrSel;
    stb.clearRead  = commit && isRd && !hostAddrSel && dirWrite;
    stb.flush      = cfgHit || ctlWr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag   <= 1'b0;
      secondByte <= 1'b0;
      enable     <= 1'b0;
      wide       <= 1'b0;
      bigEnd     <= 1'b0;
      ackMode    <= 1'b0;
      dirWrite   <= 1'b0;
      cfgWord    <= '0;
      cfgStrobe  <= 1'b0;
    end else begin
      if (!active)     doneFlag <= 1'b0;
      else if (commit) doneFlag <= 1'b1;

      if (stb.flush)
        secondByte <= 1'b0;
      else if (commit && !wide && (dataWrGo || dataRdGo))
        secondByte <= !secondByte;

      if (ctlWr) begin
        enable  <= ctlWrData[0];
        wide    <= ctlWrData[1];
        bigEnd  <= ctlWrData[2];
        ackMode <= ctlWrData[3];
      end

      cfgStrobe <= cfgHit;
      if (cfgHit) begin
        cfgWord  <= wide ? hostDataIn : {8'h00, hostDataIn[7:0]};
        dirWrite <= hostDataIn[0];
      end
    end
  end

  assign hostAck = enable && (ackMode ? doneFlag : 1'b1);
  assign hostIrq = enable && !ackMode && (dirWrite ? fifoEmpty : fifoFull);

endmodule

// File: rtl/hport_datapath.sv
module hport_datapath
  import host_port_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic             enable,
  input  logic             wide,
  input  logic             bigEnd,
  input  logic             dirWrite,
  input  logic             secondByte,
  input  logic [15:0]      hostDataIn,
  input  logic             toIntReady,
  input  logic [15:0]      fromIntData,
  input  logic             fromIntValid,
  output logic [LVL_W-1:0] level,
  output logic [15:0]      toIntData,
  output logic             toIntValid,
  output logic             fromIntReady,
  output logic [15:0]      hostDataOut
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  function automatic logic [15:0] swapBytes(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [15:0]      mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [7:0]       holdByte;
  logic [15:0]      hostWord, pushData, head, status;
  logic             intPush, intPop, push, pop;

  assign head         = mem[rdPtr];
  assign toIntData    = head;
  assign toIntValid   = enable && dirWrite && (level != '0);
  assign fromIntReady = enable && !dirWrite && (level != LVL_W'(DEPTH));
  assign intPop       = toIntValid && toIntReady;
  assign intPush      = fromIntValid && fromIntReady;

  always_comb begin
    if (wide)        hostWord = bigEnd ? swapBytes(hostDataIn) : hostDataIn;
    else if (bigEnd) hostWord = {holdByte, hostDataIn[7:0]};
    else             hostWord = {hostDataIn[7:0], holdByte};
  end

  assign push     = stb.pushWord || intPush;
  assign pop      = stb.popWord || intPop;
  assign pushData = stb.pushWord ? hostWord : fromIntData;
  assign status   = 16'(level) | (16'(dirWrite) << LVL_W);

  always_ff @(posedge clk) begin
    if (push && !stb.flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr       <= '0;
      wrPtr       <= '0;
      level       <= '0;
      holdByte    <= '0;
      hostDataOut <= '0;
    end else begin
      if (stb.flush) begin
        rdPtr <= '0;
        wrPtr <= '0;
        level <= '0;
      end else begin
        if (push) wrPtr <= nextPtr(wrPtr);
        if (pop)  rdPtr <= nextPtr(rdPtr);
        if (push && !pop)      level <= level + 1'b1;
        else if (pop && !push) level <= level - 1'b1;
      end

      if (stb.holdLo) holdByte <= hostDataIn[7:0];

      if (stb.loadStatus)
        hostDataOut <= status;
      else if (stb.clearRead)
        hostDataOut <= '0;
      else if (stb.loadData) begin
        if (wide) hostDataOut <= bigEnd ? swapBytes(head) : head;
        else      hostDataOut <= {8'h00, (secondByte ^ bigEnd) ? head[15:8] : head[7:0]};
      end
    end
  end

endmodule

// File: rtl/host_dma_slave.sv
module host_dma_slave
  import host_port_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctlWr,
  input  logic [3:0]  ctlWrData,
  input  logic        hostCsN,
  input  logic        hostRdN,
  input  logic        hostWrN,
  input  logic        hostAddrSel,
  input  logic [15:0] hostDataIn,
  output logic [15:0] hostDataOut,
  output logic        hostDataOe,
  output logic        hostAck,
  output logic        hostIrq,
  output logic [15:0] cfgWord,
  output logic        cfgStrobe,
  output logic [15:0] toIntData,
  output logic        toIntValid,
  input  logic        toIntReady,
  input  logic [15:0] fromIntData,
  input  logic        fromIntValid,
  output logic        fromIntReady
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  strobeT           stb;
  logic             enable, wide, bigEnd, ackMode, dirWrite, secondByte;
  logic [LVL_W-1:0] level;

  hport_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .ctlWrData(ctlWrData),
    .hostCsN(hostCsN), .hostRdN(hostRdN), .hostWrN(hostWrN),
    .hostAddrSel(hostAddrSel), .hostDataIn(hostDataIn), .level(level),
    .stb(stb), .enable(enable), .wide(wide), .bigEnd(bigEnd),
    .ackMode(ackMode), .dirWrite(dirWrite), .secondByte(secondByte),
    .cfgWord(cfgWord), .cfgStrobe(cfgStrobe),
    .hostAck(hostAck), .hostIrq(hostIrq)
  );

  hport_datapath #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .enable(enable), .wide(wide),
    .bigEnd(bigEnd), .dirWrite(dirWrite), .secondByte(secondByte),
    .hostDataIn(hostDataIn), .toIntReady(toIntReady),
    .fromIntData(fromIntData), .fromIntValid(fromIntValid),
    .level(level), .toIntData(toIntData), .toIntValid(toIntValid),
    .fromIntReady(fromIntReady), .hostDataOut(hostDataOut)
  );

  assign hostDataOe = enable && !hostCsN && !hostRdN;

endmodule

// File: rtl/hport_checker.sv
module hport_checker #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             ackMode,
  input logic [LVL_W-1:0] level,
  input logic             hostAck,
  input logic             hostIrq,
  input logic             toIntValid,
  input logic             fromIntReady,
  input logic             cfgStrobe
);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH)); // R11

  AST_FULL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (level == LVL_W'(DEPTH)) |-> !fromIntReady); // R11

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!hostAck && !hostIrq && !toIntValid && !fromIntReady)); // R1

  AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (!rstN)
    !(toIntValid && fromIntReady)); // R8

  AST_IRQ_BURST: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> (!ackMode && (level == '0 || level == LVL_W'(DEPTH)))); // R10

  AST_CFG_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    cfgStrobe |-> (level == '0)); // R3

  AST_CFG_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cfgStrobe |=> !cfgStrobe); // R3

endmodule

bind host_dma_slave hport_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .ackMode(ackMode),
  .level(level), .hostAck(hostAck), .hostIrq(hostIrq),
  .toIntValid(toIntValid), .fromIntReady(fromIntReady),
  .cfgStrobe(cfgStrobe)
);

// File: tb/host_dma_slave_tb.sv
module host_dma_slave_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctlWr = 1'b0;
  logic [3:0]  ctlWrData = '0;
  logic        hostCsN = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1, hostAddrSel = 1'b0;
  logic [15:0] hostDataIn = '0;
  logic [15:0] hostDataOut, cfgWord, toIntData;
  logic        hostDataOe, hostAck, hostIrq, cfgStrobe, toIntValid, fromIntReady;
  logic        toIntReady = 1'b0;
  logic [15:0] fromIntData = '0;
  logic        fromIntValid = 1'b0;

  int total = 0;
  int bad = 0;
  int cfgCnt = 0;
  bit ackOn = 1'b0;
  logic [15:0] q, q2;

  always #5 clk = ~clk;

  host_dma_slave u_dut (.*);

  always @(posedge clk) if (cfgStrobe) cfgCnt <= cfgCnt + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] swp(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  task automatic ctlSet(input logic [3:0] v);
    @(negedge clk); ctlWr = 1'b1; ctlWrData = v; ackOn = v[3];
    @(negedge clk); ctlWr = 1'b0;
  endtask

  task automatic hostAcc(input bit wr, input bit regSel, input logic [15:0] d, output logic [15:0] r);
    bit got;
    @(negedge clk);
    hostCsN = 1'b0; hostAddrSel = regSel; hostDataIn = d;
    if (wr) hostWrN = 1'b0; else hostRdN = 1'b0;
    got = 1'b0;
    if (ackOn) begin
      for (int i = 0; i < 40 && !got; i++) begin
        @(negedge clk);
        if (hostAck) got = 1'b1;
      end
      if (!got) chk(1'b0, "R9 ack timeout", 0, 1);
    end else begin
      @(negedge clk); @(negedge clk);
    end
    r = hostDataOut;
    hostCsN = 1'b1; hostRdN = 1'b1; hostWrN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] w [4];
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!hostAck && !hostIrq && !toIntValid && !fromIntReady, "R1 reset quiet",
        {hostAck, hostIrq, toIntValid, fromIntReady}, 0);

    // R1: disabled port ignores a held config write
    hostCsN = 1'b0; hostWrN = 1'b0; hostAddrSel = 1'b1; hostDataIn = 16'h0001;
    repeat (5) @(negedge clk);
    chk(!hostAck, "R1 no ack when disabled", hostAck, 0);
    hostCsN = 1'b1; hostWrN = 1'b1;
    @(negedge clk);
    chk(cfgCnt == 0 && cfgWord == 0, "R1 no cfg when disabled", cfgWord, 0);

    // Sweep width x endian, both directions
    for (int m = 0; m < 4; m++) begin
      bit wd, be;
      wd = m[1]; be = m[0];
      ctlSet({1'b1, be, wd, 1'b1});               // R2 field positions
      n = cfgCnt;
      hostAcc(1, 1, 16'hA501, q);
      chk(cfgCnt == n + 1, "R3 single cfg strobe", cfgCnt - n, 1);
      chk(cfgWord == (wd ? 16'hA501 : 16'h0001), "R3 cfg word", cfgWord, wd ? 16'hA501 : 16'h0001);
      for (int k = 0; k < 4; k++) w[k] = 16'(k * 16'h2345 + m * 16'h0111 + 16'h1A2B);
      for (int k = 0; k < 4; k++) begin
        if (wd) hostAcc(1, 0, be ? swp(w[k]) : w[k], q);
        else begin
          hostAcc(1, 0, {8'hC3, be ? w[k][15:8] : w[k][7:0]}, q);
          hostAcc(1, 0, {8'h3C, be ? w[k][7:0] : w[k][15:8]}, q);
        end
      end
      hostAcc(0, 1, 0, q);
      chk(q == 16'h0014, "R4 status write dir level 4", q, 16'h0014);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); toIntReady = 1'b1; #1;
        chk(toIntValid && toIntData == w[k], wd ? "R5 wide write word" : "R6 byte pack word",
            toIntData, w[k]);
        @(negedge clk); toIntReady = 1'b0;
      end
      // read direction
      hostAcc(1, 1, 16'h0000, q);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); fromIntValid = 1'b1; fromIntData = w[k];
      end
      @(negedge clk); fromIntValid = 1'b0;
      hostAcc(0, 1, 0, q);
      chk(q == 16'h0004, "R4 status read dir level 4", q, 16'h0004);
      for (int k = 0; k < 4; k++) begin
        if (wd) begin
          hostAcc(0, 0, 0, q);
          chk(q == (be ? swp(w[k]) : w[k]), "R7 wide read", q, be ? swp(w[k]) : w[k]);
        end else begin
          hostAcc(0, 0, 0, q);
          hostAcc(0, 0, 0, q2);
          chk(q == {8'h00, be ? w[k][15:8] : w[k][7:0]}, "R7 first byte", q,
              {8'h00, be ? w[k][15:8] : w[k][7:0]});
          chk(q2 == {8'h00, be ? w[k][7:0] : w[k][15:8]}, "R7 second byte", q2,
              {8'h00, be ? w[k][7:0] : w[k][15:8]});
        end
      end
      hostAcc(0, 1, 0, q);
      chk(q == 16'h0000, "R7 fifo drained", q, 0);
    end

    // R11: depth in read direction
    ctlSet(4'b1011);
    hostAcc(1, 1, 16'h0000, q);
    n = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); fromIntValid = 1'b1; fromIntData = 16'(i);
      #1; if (fromIntReady) n++;
    end
    @(negedge clk); fromIntValid = 1'b0;
    chk(n == 8 && !fromIntReady, "R11 accepts eight words", n, 8);
    hostAcc(0, 1, 0, q);
    chk(q == 16'h0008, "R4 status full", q, 16'h0008);

    // R9: read stalls on empty
    hostAcc(1, 1, 16'h0000, q);
    @(negedge clk); hostCsN = 1'b0; hostRdN = 1'b0; hostAddrSel = 1'b0;
    repeat (5) @(negedge clk);
    chk(!hostAck, "R9 read waits while empty", hostAck, 0);
    fromIntValid = 1'b1; fromIntData = 16'hBEEF;
    @(negedge clk); fromIntValid = 1'b0;
    @(negedge clk);
    chk(hostAck && hostDataOut == 16'hBEEF, "R9 read completes", hostDataOut, 16'hBEEF);
    hostCsN = 1'b1; hostRdN = 1'b1;
    @(negedge clk);

    // R9: write stalls on full
    hostAcc(1, 1, 16'h0001, q);
    for (int i = 0; i < 8; i++) hostAcc(1, 0, 16'(16'h0100 + i), q);
    hostAcc(0, 1, 0, q);
    chk(q == 16'h0018, "R4 status write full", q, 16'h0018);
    @(negedge clk); hostCsN = 1'b0; hostWrN = 1'b0; hostAddrSel = 1'b0; hostDataIn = 16'h5555;
    repeat (5) @(negedge clk);
    chk(!hostAck, "R9 write waits while full", hostAck, 0);
    toIntReady = 1'b1; #1;
    chk(toIntData == 16'h0100, "R9 oldest word first", toIntData, 16'h0100);
    @(negedge clk); toIntReady = 1'b0;
    @(negedge clk);
    chk(hostAck, "R9 write completes after drain", hostAck, 1);
    hostCsN = 1'b1; hostWrN = 1'b1;
    @(negedge clk);

    // R8: half duplex
    hostAcc(1, 1, 16'h0000, q);
    hostAcc(1, 0, 16'h7777, q);
    hostAcc(0, 1, 0, q);
    chk(q == 16'h0000 && !toIntValid, "R8 write against read dir ignored", q, 0);
    hostAcc(1, 1, 16'h0001, q);
    hostAcc(0, 0, 0, q);
    chk(q == 16'h0000, "R8 read against write dir returns zero", q, 0);
    hostAcc(0, 1, 0, q);
    chk(q == 16'h0010 && !fromIntReady, "R8 level unchanged", q, 16'h0010);

    // R10: interrupt mode
    ctlSet(4'b0011);
    @(negedge clk);
    chk(hostAck, "R10 ack held high", hostAck, 1);
    hostAcc(1, 1, 16'h0001, q);
    chk(hostIrq, "R10 irq write dir empty", hostIrq, 1);
    hostAcc(1, 0, 16'h1234, q);
    chk(!hostIrq, "R10 irq drops with one word", hostIrq, 0);
    hostAcc(1, 1, 16'h0000, q);
    chk(!hostIrq, "R10 no irq read dir empty", hostIrq, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); fromIntValid = 1'b1; fromIntData = 16'(i);
    end
    @(negedge clk); fromIntValid = 1'b0;
    chk(hostIrq, "R10 irq read dir full", hostIrq, 1);
    hostAcc(0, 0, 0, q);
    chk(!hostIrq && q == 16'h0000, "R10 irq drops after read", {hostIrq, q}, 0);

    // R1/R2: disable
    ctlSet(4'b0000);
    @(negedge clk);
    chk(!hostAck && !hostIrq && !fromIntReady, "R2 disable clears outputs",
        {hostAck, hostIrq, fromIntReady}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule